// File: doc/BRIEF.md
# Stop-Mode Wake-Up Delay Counter

This block sets how long the system waits after leaving a low-power stop state before its clocks are treated as stable. It runs on a reference clock at four times the bus rate. A stop request clears the count and parks the block in a halted state. The first interrupt, break or reset wake event then starts a delay. The length of that delay comes from a short-recovery configuration bit, which is captured at the moment of the wake. A short delay suits a ready-made oscillator module. The long delay gives a crystal time to settle.

When the selected number of reference cycles has elapsed, the block raises a one-cycle completion pulse and sets a ready flag. The flag stays high until the next stop request. Outside stop the counter runs freely. An external reset pin is routed to the block but has no influence on the count or on the outputs. All pins are plain control and status signals. No data flows through the block, so it has no valid/ready handshake.

Top module: `swd_top`

## Requirements
- R1: After the internal reset (rst_n low) is released, clk_ready is 1 and done_pulse is 0.
- R2: When stop_req is high at a clock edge while the block is running or counting a delay, clk_ready is 0 from that edge onward and the count restarts from zero.
- R3: While halted with no wake input high, clk_ready stays 0 and done_pulse stays 0 for any length of time.
- R4: Each of wake_irq, wake_brk and wake_rst, alone, ends the halted state and starts a delay.
- R5: With short_rec = 1 at the wake edge, done_pulse is 1 exactly in the cycle after the 32nd clock edge that follows the wake edge, and not before.
- R6: With short_rec = 0 at the wake edge, done_pulse is 1 exactly in the cycle after the 4096th clock edge that follows the wake edge, and not before.
- R7: short_rec is sampled only at the wake edge. Changing it while a delay is counting does not change that delay's length.
- R8: done_pulse is high for exactly one cycle and clk_ready rises together with it. clk_ready then stays 1 until the next stop request.
- R9: A wake input that goes high while a delay is already counting has no effect on when done_pulse occurs.
- R10: ext_rst has no effect. It does not wake a halted block, and it does not shift or cancel a delay in progress.
- R11: A stop request during a delay cancels it. No done_pulse follows until a new wake event, and that new wake event then runs a full delay.
- R12: While running (clk_ready = 1), the wake inputs produce no done_pulse and do not clear clk_ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock, four times the bus rate |
| rst_n | input | 1 | Internal reset, active low, asynchronous |
| ext_rst | input | 1 | External reset pin level; has no effect on the block |
| stop_req | input | 1 | Request to enter the halted stop state |
| wake_irq | input | 1 | Interrupt wake source |
| wake_brk | input | 1 | Break wake source |
| wake_rst | input | 1 | Reset wake source |
| short_rec | input | 1 | 1 selects the short recovery delay, 0 the long one |
| done_pulse | output | 1 | One-cycle pulse when the recovery delay ends |
| clk_ready | output | 1 | High while the clocks are considered stable |

## Verification
The bench builds the block with its default parameters: a 12-bit counter, a 4096-cycle long delay and a 32-cycle short delay. With these values the long delay ends exactly where the counter wraps from its all-ones value back to zero, so the wrap and the terminal match are tested at the same edge. Each long run takes a few thousand cycles, which leaves room to repeat it with an external reset held across the whole delay. The short delay is brief enough that cancelling a delay, changing short_rec during a count and arriving wake events are each tested at exact edges.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic [1:0] {
    SWD_RUN  = 2'd0,
    SWD_HALT = 2'd1,
    SWD_WAIT = 2'd2
  } swd_state_e;

  localparam int SWD_NUM_SRC = 3;

endpackage

// File: rtl/swd_wake_latch.sv
module swd_wake_latch #(
  parameter int NSRC = 3
) (
  input  logic            clk_ref,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            arm_i,
  input  logic            short_rec_i,
  output logic            wake_hit_o,
  output logic            short_q_o
);

  logic [NSRC-1:0] any_chain;

  // OR chain over wake sources
  for (genvar g = 0; g < NSRC; g++) begin : g_or
    if (g == 0) begin : g_first
      assign any_chain[g] = src_i[g];
    end else begin : g_rest
      assign any_chain[g] = any_chain[g-1] | src_i[g];
    end
  end

  assign wake_hit_o = arm_i & any_chain[NSRC-1];

  // Delay choice captured only on the accepted wake edge
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      short_q_o <= 1'b0;
    end else if (wake_hit_o) begin
      short_q_o <= short_rec_i;
    end
  end

endmodule

// File: rtl/swd_limit_sel.sv
module swd_limit_sel #(
  parameter int CNT_W     = 12,
  parameter int SHORT_CYC = 32,
  parameter int LONG_CYC  = 4096
) (
  input  logic             short_q_i,
  output logic [CNT_W-1:0] term_o
);

  localparam logic [CNT_W-1:0] SHORT_TERM = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_TERM  = CNT_W'(LONG_CYC - 1);

  assign term_o = short_q_i ? SHORT_TERM : LONG_TERM;

endmodule

// File: rtl/swd_counter.sv
module swd_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             at_term_o
);

  logic [CNT_W-1:0] cnt_q;

  // Wraps naturally; never cleared by anything but clr_i or rst_n
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign at_term_o = (cnt_q == term_i);

endmodule

// File: rtl/swd_ctrl.sv
module swd_ctrl
  import swd_pkg::*;
(
  input  logic clk_ref,
  input  logic rst_n,
  input  logic stop_req_i,
  input  logic wake_src_any_i,
  input  logic at_term_i,
  output logic arm_o,
  output logic cnt_clr_o,
  output logic cnt_en_o,
  output logic done_pulse_o,
  output logic ready_o
);

  swd_state_e state_q, state_d;
  logic       stop_take;
  logic       finish;

  assign arm_o     = (state_q == SWD_HALT);
  assign stop_take = stop_req_i && (state_q != SWD_HALT);
  assign finish    = (state_q == SWD_WAIT) && at_term_i && !stop_take;
  assign cnt_clr_o = stop_take;
  assign cnt_en_o  = (state_q != SWD_HALT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SWD_RUN:  if (stop_take) state_d = SWD_HALT;
      SWD_HALT: if (wake_src_any_i) state_d = SWD_WAIT;
      SWD_WAIT: begin
        if (stop_take)   state_d = SWD_HALT;
        else if (finish) state_d = SWD_RUN;
      end
      default:  state_d = SWD_RUN;
    endcase
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SWD_RUN;
      done_pulse_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      done_pulse_o <= finish;
    end
  end

  assign ready_o = (state_q == SWD_RUN);

endmodule

// File: rtl/swd_top.sv
module swd_top
  import swd_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int SHORT_CYC = 32,
  parameter int LONG_CYC  = 4096
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic ext_rst,
  input  logic stop_req,
  input  logic wake_irq,
  input  logic wake_brk,
  input  logic wake_rst,
  input  logic short_rec,
  output logic done_pulse,
  output logic clk_ready
);

  logic [SWD_NUM_SRC-1:0] src;
  logic                   arm;
  logic                   wake_hit;
  logic                   short_q;
  logic [CNT_W-1:0]       term;
  logic                   at_term;
  logic                   cnt_clr;
  logic                   cnt_en;

  assign src = {wake_rst, wake_brk, wake_irq};

  swd_wake_latch #(.NSRC(SWD_NUM_SRC)) u_wake (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .src_i      (src),
    .arm_i      (arm),
    .short_rec_i(short_rec),
    .wake_hit_o (wake_hit),
    .short_q_o  (short_q)
  );

  swd_limit_sel #(.CNT_W(CNT_W), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_sel (
    .short_q_i(short_q),
    .term_o   (term)
  );

  swd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .clr_i    (cnt_clr),
    .en_i     (cnt_en),
    .term_i   (term),
    .at_term_o(at_term)
  );

  swd_ctrl u_ctrl (
    .clk_ref       (clk_ref),
    .rst_n         (rst_n),
    .stop_req_i    (stop_req),
    .wake_src_any_i(wake_hit),
    .at_term_i     (at_term),
    .arm_o         (arm),
    .cnt_clr_o     (cnt_clr),
    .cnt_en_o      (cnt_en),
    .done_pulse_o  (done_pulse),
    .ready_o       (clk_ready)
  );

endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
  parameter int SHORT_CYC = 32,
  parameter int LONG_CYC  = 4096
) (
  input logic clk_ref,
  input logic rst_n,
  input logic ext_rst,
  input logic stop_req,
  input logic wake_irq,
  input logic wake_brk,
  input logic wake_rst,
  input logic short_rec,
  input logic done_pulse,
  input logic clk_ready
);

  localparam int LW = $clog2(LONG_CYC + 1) + 1;

  logic          halted, waiting, sh_l, any_wake;
  logic [LW-1:0] wcnt, len, nxt;

  assign any_wake = wake_irq | wake_brk | wake_rst;
  assign len      = sh_l ? LW'(SHORT_CYC) : LW'(LONG_CYC);
  assign nxt      = wcnt + LW'(1);

  // Port-level reference of halt / wait timing
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      halted  <= 1'b0;
      waiting <= 1'b0;
      wcnt    <= '0;
      sh_l    <= 1'b0;
    end else if (stop_req && !halted) begin
      halted  <= 1'b1;
      waiting <= 1'b0;
      wcnt    <= '0;
    end else if (halted && any_wake) begin
      halted  <= 1'b0;
      waiting <= 1'b1;
      wcnt    <= '0;
      sh_l    <= short_rec;
    end else if (waiting) begin
      wcnt <= nxt;
      if (nxt == len) waiting <= 1'b0;
    end
  end

  a_r2_stop_drops_ready: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (stop_req && clk_ready) |=> !clk_ready);

  a_r3_halted_quiet: assert property (@(posedge clk_ref) disable iff (!rst_n)
    halted |-> (!clk_ready && !done_pulse));

  a_r5_done_on_time: assert property (@(posedge clk_ref) disable iff (!rst_n)
    done_pulse |-> (!waiting && wcnt == len));

  a_r6_done_not_missed: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (waiting && nxt == len && !stop_req) |=> done_pulse);

  a_r8_single_pulse: assert property (@(posedge clk_ref) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  a_r8_ready_rises_with_done: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(clk_ready) |-> done_pulse);

  a_r10_ext_rst_no_wake: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (halted && ext_rst && !any_wake) |=> !clk_ready);

endmodule

bind swd_top swd_checker #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_swd_chk (
  .clk_ref   (clk_ref),
  .rst_n     (rst_n),
  .ext_rst   (ext_rst),
  .stop_req  (stop_req),
  .wake_irq  (wake_irq),
  .wake_brk  (wake_brk),
  .wake_rst  (wake_rst),
  .short_rec (short_rec),
  .done_pulse(done_pulse),
  .clk_ready (clk_ready)
);

// File: tb/test_swd_top.sv
`timescale 1ns/1ps
module test_swd_top;

  localparam int SHORT_N = 32;
  localparam int LONG_N  = 4096;

  logic clk_ref = 1'b0;
  logic rst_n = 1'b0;
  logic ext_rst = 1'b0, stop_req = 1'b0, short_rec = 1'b0;
  logic wake_irq = 1'b0, wake_brk = 1'b0, wake_rst = 1'b0;
  logic done_pulse, clk_ready;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk_ref = ~clk_ref;

  swd_top i_swd_top (
    .clk_ref(clk_ref), .rst_n(rst_n), .ext_rst(ext_rst), .stop_req(stop_req),
    .wake_irq(wake_irq), .wake_brk(wake_brk), .wake_rst(wake_rst),
    .short_rec(short_rec), .done_pulse(done_pulse), .clk_ready(clk_ready)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_wake(input int src, input bit v);
    case (src)
      0: wake_irq = v;
      1: wake_brk = v;
      default: wake_rst = v;
    endcase
  endtask

  task automatic enter_stop(input string tag);
    @(negedge clk_ref); stop_req = 1'b1;
    @(posedge clk_ref);
    @(negedge clk_ref); stop_req = 1'b0;
    check(clk_ready == 1'b0, tag, clk_ready, 0);
  endtask

  // Wake edge happens inside; returns at the negedge after it
  task automatic wake(input int src, input bit sh);
    @(negedge clk_ref); set_wake(src, 1'b1); short_rec = sh;
    @(posedge clk_ref);
    @(negedge clk_ref); set_wake(src, 1'b0);
  endtask

  // kind: 0 none, 1 flip short_rec, 2 extra wake, 3 ext_rst held
  task automatic expect_done(input int n, input int kind, input string tag);
    int bad = 0;
    for (int i = 1; i < n; i++) begin
      @(posedge clk_ref);
      @(negedge clk_ref);
      if (done_pulse || clk_ready) bad++;
      if (kind == 1 && i == n / 2) short_rec = ~short_rec;
      if (kind == 2) begin
        wake_brk = (i == n / 2);
        wake_irq = (i == n / 2 + 1);
      end
      if (kind == 3) ext_rst = 1'b1;
    end
    wake_brk = 1'b0; wake_irq = 1'b0;
    check(bad == 0, {tag, " early done/ready"}, bad, 0);
    @(posedge clk_ref);
    @(negedge clk_ref);
    check(done_pulse == 1'b1 && clk_ready == 1'b1, {tag, " done at terminal"},
          {done_pulse, clk_ready}, 3);
    ext_rst = 1'b0;
    @(posedge clk_ref);
    @(negedge clk_ref);
    check(done_pulse == 1'b0 && clk_ready == 1'b1, {tag, " R8 single pulse"},
          {done_pulse, clk_ready}, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk_ref);
    @(negedge clk_ref); rst_n = 1'b1;
    @(negedge clk_ref);
    check(clk_ready == 1'b1 && done_pulse == 1'b0, "R1 reset state",
          {clk_ready, done_pulse}, 2);
  endtask

  task automatic t_running_wakes();
    int bad = 0;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk_ref); set_wake(s, 1'b1); short_rec = 1'b1;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk_ref);
        if (done_pulse || !clk_ready) bad++;
      end
      set_wake(s, 1'b0);
    end
    check(bad == 0, "R12 wakes ignored while running", bad, 0);
  endtask

  task automatic t_halt_quiet();
    int bad = 0;
    enter_stop("R2 stop from running");
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk_ref);
      if (done_pulse || clk_ready) bad++;
    end
    check(bad == 0, "R3 halted stays quiet", bad, 0);
  endtask

  task automatic t_short_each_source();
    for (int s = 0; s < 3; s++) begin
      enter_stop("R2 stop entry");
      wake(s, 1'b1);
      expect_done(SHORT_N, 0, $sformatf("R4 R5 source %0d", s));
    end
  endtask

  task automatic t_long();
    enter_stop("R2 stop entry");
    wake(0, 1'b0);
    expect_done(LONG_N, 0, "R6 long delay");
    check(clk_ready == 1'b1, "R8 ready holds after done", clk_ready, 1);
  endtask

  task automatic t_latch_short();
    enter_stop("R2 stop entry");
    wake(1, 1'b1);
    expect_done(SHORT_N, 1, "R7 short kept after flip");
    enter_stop("R2 stop entry");
    wake(2, 1'b0);
    expect_done(LONG_N, 1, "R7 long kept after flip");
  endtask

  task automatic t_wake_during_delay();
    enter_stop("R2 stop entry");
    wake(2, 1'b1);
    expect_done(SHORT_N, 2, "R9 extra wake ignored");
  endtask

  task automatic t_ext_rst();
    int bad = 0;
    enter_stop("R2 stop entry");
    @(negedge clk_ref); ext_rst = 1'b1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk_ref);
      if (clk_ready || done_pulse) bad++;
    end
    ext_rst = 1'b0;
    check(bad == 0, "R10 ext_rst does not wake", bad, 0);
    wake(0, 1'b0);
    expect_done(LONG_N, 3, "R10 ext_rst during long delay");
    @(negedge clk_ref); ext_rst = 1'b1;
    repeat (5) @(negedge clk_ref);
    check(clk_ready == 1'b1, "R10 ext_rst while running", clk_ready, 1);
    ext_rst = 1'b0;
  endtask

  task automatic t_stop_cancels();
    int bad = 0;
    enter_stop("R2 stop entry");
    wake(0, 1'b1);
    repeat (10) @(negedge clk_ref);
    enter_stop("R11 stop during delay");
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_ref);
      if (clk_ready || done_pulse) bad++;
    end
    check(bad == 0, "R11 cancelled delay stays quiet", bad, 0);
    wake(1, 1'b1);
    expect_done(SHORT_N, 0, "R11 full delay after rewake");
  endtask

  task automatic run_all();
    t_reset();
    t_running_wakes();
    t_halt_quiet();
    t_short_each_source();
    t_long();
    t_latch_short();
    t_wake_during_delay();
    t_ext_rst();
    t_stop_cancels();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk_ref);
        n_checks++;
        n_fails++;
        $display("FAIL R8 watchdog: got %0d expected %0d", 150000, 0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule